// File: doc/BRIEF.md
# PLL Configuration and Clock Gate Controller

This block holds the configuration of a clock synthesiser and the run/stop state of sixteen peripheral clocks, behind a small register write/read port. Software sets a feedback multiplier, an input divider and an output divider for the synthesiser, along with an enable bit, a bypass bit and a settle count. A small state machine models the lock handshake. Once the enable bit is set, it waits a programmed number of reference cycles and then raises a stable flag, which software can poll.

The block also computes the synthesiser ratio as a numerator and a denominator so that a checker can follow the programmed frequency. Each bit of the gate register drives one active-high stop line. Four more bits carry the wait-mode choice (sleep or idle), doze, the USB device clock enable and USB host suspend.

The settle state machine has three states:

- `ST_OFF`: the synthesiser is off.
- `ST_SETTLE`: the settle counter is running.
- `ST_LOCKED`: the stable flag is raised.

It moves between them as follows:

- `ST_OFF` to `ST_SETTLE` when enable is seen and the settle count is non-zero. The counter is loaded with count × 8.
- `ST_OFF` to `ST_LOCKED` when enable is seen and the settle count is zero.
- `ST_SETTLE` to `ST_LOCKED` when the counter reaches its last cycle.
- `ST_SETTLE` to `ST_OFF` and `ST_LOCKED` to `ST_OFF` when enable is seen low.

Top module: `clkpll_ctrl`

## Requirements
- R1: After reset, every register field reads 0, except the gate register at offset 0x20, which reads 0x0000FFFF. `gate_stop` is all ones and `pll_stable` is 0.
- R2: The synthesiser register at offset 0x10 stores and reads back the following fields. All other bits read 0.
  - M in bits 31:23.
  - N in bits 22:18.
  - OD in bits 17:16.
  - Bypass in bit 9.
  - Enable in bit 8.
  - Settle count in bits 3:0.
- R3: When bypass is 0, `ratio_num` = M+2 and `ratio_den` = (N+2)×F, where OD codes 0, 1, 2 and 3 give F = 1, 2, 2 and 4.
- R4: When bypass is 1, `ratio_num` = 1 and `ratio_den` = 1, whatever the values of M, N and OD.
- R5: Let a write set enable with settle count C, and let that write take effect at clock edge E. Then `pll_stable` is 0 after each edge up to E+8C and is 1 after edge E+1+8C. With C=0, the flag is 1 after the very next edge.
- R6: Let a write clear enable at edge D. Then `pll_stable` is 0 after edge D+1. A later enable restarts the full settle delay, even if the earlier settling was not finished.
- R7: Bit 10 of offset 0x10 reads as `pll_stable`. Writes to bit 10 have no effect.
- R8: At offset 0x20, bit i drives `gate_stop[i]`, where 1 means stopped and 0 means running. The bit order, from 0 to 15, is: UART0, timer, RTC, I2C, SPI, AIC, I2S, MMC, ADC, CIM, LCD, UDC, DMAC, IPU, UHC, UART1.
- R9: At offset 0x04, bit 0 drives `sleep_on_wait` and bit 2 drives `doze_en`. At offset 0x24, bit 6 drives `usbd_clk_en` and bit 7 drives `usbh_suspend`. All other bits of these two registers read 0.
- R10: A write to any unmapped offset changes no output and no register. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| gate_stop | output | GATE_N | Per-peripheral clock stop, 1 = stopped |
| pll_en | output | 1 | Synthesiser enable |
| pll_bypass | output | 1 | Reference passed through |
| pll_stable | output | 1 | Lock handshake complete |
| ratio_num | output | 10 | Ratio numerator |
| ratio_den | output | 8 | Ratio denominator |
| sleep_on_wait | output | 1 | Wait enters sleep rather than idle |
| doze_en | output | 1 | Doze mode |
| usbd_clk_en | output | 1 | USB device clock enable |
| usbh_suspend | output | 1 | USB host suspend |

## Verification
The ratio is tried with three kinds of values:

- all-zero fields, which give the +2 offsets alone;
- all-ones fields, which give the widest numerator and denominator;
- mid values for each OD code, which separate the doubled codes 1 and 2 from code 3.

A bypass entry with non-trivial fields shows that the formula is overridden.

The settle handshake is run with settle counts 0, 2 and 15. At each count the flag is compared cycle by cycle against a window of 1+8C edges, which exposes off-by-one and prescale errors. An enable that is dropped midway and then given again shows that the counter restarts.

Walking gate bits, writes to mapped and unmapped offsets, and writes to the read-only stable bit show that each field reaches only its own output.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
    localparam logic [7:0] OFS_LPWR = 8'h04;
    localparam logic [7:0] OFS_PLL  = 8'h10;
    localparam logic [7:0] OFS_GATE = 8'h20;
    localparam logic [7:0] OFS_SLPC = 8'h24;

    localparam int M_W      = 9;
    localparam int N_W      = 5;
    localparam int OD_W     = 2;
    localparam int SETTLE_W = 4;
    localparam int NUM_W    = M_W + 1;
    localparam int DEN_W    = N_W + 3;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_SETTLE = 2'd1,
        ST_LOCKED = 2'd2
    } settle_state_e;

    typedef struct packed {
        logic [M_W-1:0]      m;
        logic [N_W-1:0]      n;
        logic [OD_W-1:0]     od;
        logic                bypass;
        logic                enable;
        logic [SETTLE_W-1:0] settle;
    } pll_cfg_t;
endpackage

// File: rtl/pcg_regs.sv
module pcg_regs
    import pcg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int GATE_N = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              pll_stable,
    output pll_cfg_t          cfg,
    output logic [GATE_N-1:0] gate_q,
    output logic              lp_sleep,
    output logic              lp_doze,
    output logic              usbd_en,
    output logic              usbh_susp,
    output logic [31:0]       rdata
);
    logic hit_pll, hit_gate, hit_lpwr, hit_slpc;

    assign hit_pll  = (addr == ADDR_W'(OFS_PLL));
    assign hit_gate = (addr == ADDR_W'(OFS_GATE));
    assign hit_lpwr = (addr == ADDR_W'(OFS_LPWR));
    assign hit_slpc = (addr == ADDR_W'(OFS_SLPC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg       <= '0;
            gate_q    <= '1;
            lp_sleep  <= 1'b0;
            lp_doze   <= 1'b0;
            usbd_en   <= 1'b0;
            usbh_susp <= 1'b0;
        end else if (wr_en) begin
            if (hit_pll) begin
                cfg.m      <= wdata[31:23];
                cfg.n      <= wdata[22:18];
                cfg.od     <= wdata[17:16];
                cfg.bypass <= wdata[9];
                cfg.enable <= wdata[8];
                cfg.settle <= wdata[3:0];
            end
            if (hit_gate) gate_q <= wdata[GATE_N-1:0];
            if (hit_lpwr) begin
                lp_sleep <= wdata[0];
                lp_doze  <= wdata[2];
            end
            if (hit_slpc) begin
                usbd_en   <= wdata[6];
                usbh_susp <= wdata[7];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (hit_pll) begin
            rdata[31:23] = cfg.m;
            rdata[22:18] = cfg.n;
            rdata[17:16] = cfg.od;
            rdata[10]    = pll_stable;
            rdata[9]     = cfg.bypass;
            rdata[8]     = cfg.enable;
            rdata[3:0]   = cfg.settle;
        end
        if (hit_gate) rdata[GATE_N-1:0] = gate_q;
        if (hit_lpwr) begin
            rdata[0] = lp_sleep;
            rdata[2] = lp_doze;
        end
        if (hit_slpc) begin
            rdata[6] = usbd_en;
            rdata[7] = usbh_susp;
        end
    end
endmodule

// File: rtl/pcg_settle.sv
module pcg_settle
    import pcg_pkg::*;
#(
    parameter int CNT_IN_W = 4,
    parameter int PRESCALE = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [CNT_IN_W-1:0] settle,
    output logic                stable
);
    localparam int MAX_LOAD = PRESCALE * ((1 << CNT_IN_W) - 1);
    localparam int CNT_W    = $clog2(MAX_LOAD + 1);

    settle_state_e    state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] load_val;

    assign load_val = CNT_W'(settle) * CNT_W'(PRESCALE);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OFF: begin
                cnt_d = load_val;
                if (enable) begin
                    if (load_val == '0) state_d = ST_LOCKED;
                    else                state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (!enable)                     state_d = ST_OFF;
                else if (cnt_q == CNT_W'(1))     state_d = ST_LOCKED;
                else                             cnt_d   = cnt_q - CNT_W'(1);
            end
            ST_LOCKED: begin
                if (!enable) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        stable = (state_q == ST_LOCKED);
    end
endmodule

// File: rtl/pcg_ratio.sv
module pcg_ratio
    import pcg_pkg::*;
(
    input  logic [M_W-1:0]   m,
    input  logic [N_W-1:0]   n,
    input  logic [OD_W-1:0]  od,
    input  logic             bypass,
    output logic [NUM_W-1:0] num,
    output logic [DEN_W-1:0] den
);
    logic [1:0]       od_shift;
    logic [DEN_W-1:0] n_plus;

    always_comb begin
        unique case (od)
            2'd0:    od_shift = 2'd0;
            2'd1:    od_shift = 2'd1;
            2'd2:    od_shift = 2'd1;
            default: od_shift = 2'd2;
        endcase
    end

    assign n_plus = DEN_W'(n) + DEN_W'(2);

    always_comb begin
        if (bypass) begin
            num = NUM_W'(1);
            den = DEN_W'(1);
        end else begin
            num = NUM_W'(m) + NUM_W'(2);
            den = n_plus << od_shift;
        end
    end
endmodule

// File: rtl/clkpll_ctrl.sv
module clkpll_ctrl
    import pcg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int GATE_N   = 16,
    parameter int PRESCALE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [GATE_N-1:0] gate_stop,
    output logic              pll_en,
    output logic              pll_bypass,
    output logic              pll_stable,
    output logic [NUM_W-1:0]  ratio_num,
    output logic [DEN_W-1:0]  ratio_den,
    output logic              sleep_on_wait,
    output logic              doze_en,
    output logic              usbd_clk_en,
    output logic              usbh_suspend
);
    pll_cfg_t cfg;

    pcg_regs #(.ADDR_W(ADDR_W), .GATE_N(GATE_N)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .pll_stable (pll_stable),
        .cfg        (cfg),
        .gate_q     (gate_stop),
        .lp_sleep   (sleep_on_wait),
        .lp_doze    (doze_en),
        .usbd_en    (usbd_clk_en),
        .usbh_susp  (usbh_suspend),
        .rdata      (rdata)
    );

    pcg_settle #(.CNT_IN_W(SETTLE_W), .PRESCALE(PRESCALE)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (cfg.enable),
        .settle (cfg.settle),
        .stable (pll_stable)
    );

    pcg_ratio u_ratio (
        .m      (cfg.m),
        .n      (cfg.n),
        .od     (cfg.od),
        .bypass (cfg.bypass),
        .num    (ratio_num),
        .den    (ratio_den)
    );

    assign pll_en     = cfg.enable;
    assign pll_bypass = cfg.bypass;
endmodule

// File: rtl/clkpll_ctrl_chk.sv
module clkpll_ctrl_chk
    import pcg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int GATE_N = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic [GATE_N-1:0] gate_stop,
    input logic              pll_en,
    input logic              pll_bypass,
    input logic              pll_stable,
    input logic [NUM_W-1:0]  ratio_num,
    input logic [DEN_W-1:0]  ratio_den
);
    // R6
    disable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_en |=> !pll_stable);

    // R5
    stable_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_stable) |-> $past(pll_en));

    // R4
    bypass_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_bypass |-> (ratio_num == NUM_W'(1) && ratio_den == DEN_W'(1)));

    // R3
    ratio_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_bypass |-> (ratio_num >= NUM_W'(2) && ratio_den >= DEN_W'(2)));

    // R7
    stable_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(OFS_PLL)) |-> (rdata[10] == pll_stable));

    // R10
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != ADDR_W'(OFS_GATE)) |=> $stable(gate_stop));
endmodule

bind clkpll_ctrl clkpll_ctrl_chk #(.ADDR_W(ADDR_W), .GATE_N(GATE_N)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .addr       (addr),
    .rdata      (rdata),
    .gate_stop  (gate_stop),
    .pll_en     (pll_en),
    .pll_bypass (pll_bypass),
    .pll_stable (pll_stable),
    .ratio_num  (ratio_num),
    .ratio_den  (ratio_den)
);

// File: tb/clkpll_ctrl_test.sv
`timescale 1ns/1ps
module clkpll_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic [15:0] gate_stop;
    logic        pll_en, pll_bypass, pll_stable;
    logic [9:0]  ratio_num;
    logic [7:0]  ratio_den;
    logic        sleep_on_wait, doze_en, usbd_clk_en, usbh_suspend;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    clkpll_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .gate_stop(gate_stop), .pll_en(pll_en),
        .pll_bypass(pll_bypass), .pll_stable(pll_stable),
        .ratio_num(ratio_num), .ratio_den(ratio_den),
        .sleep_on_wait(sleep_on_wait), .doze_en(doze_en),
        .usbd_clk_en(usbd_clk_en), .usbh_suspend(usbh_suspend)
    );

    // fields: m(9) n(5) od(2) bypass(1) exp_num(10) exp_den(8)
    localparam logic [34:0] VEC [6] = '{
        {9'd0,   5'd0,  2'd0, 1'b0, 10'd2,   8'd2},
        {9'd511, 5'd31, 2'd3, 1'b0, 10'd513, 8'd132},
        {9'd10,  5'd3,  2'd1, 1'b0, 10'd12,  8'd10},
        {9'd100, 5'd7,  2'd2, 1'b0, 10'd102, 8'd18},
        {9'd5,   5'd1,  2'd3, 1'b0, 10'd7,   8'd12},
        {9'd50,  5'd2,  2'd1, 1'b1, 10'd1,   8'd1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic settle_run(input logic [3:0] c, input string req);
        int errs = 0;
        int win;
        win = 1 + 8 * int'(c);
        wr(8'h10, 32'h0000_0100 | {28'h0, c});
        for (int k = 1; k <= win + 2; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (pll_stable !== (k >= win)) begin
                errs++;
                if (errs == 1)
                    $display("FAIL %s: cycle %0d stable %0b expected %0b", req, k, pll_stable, (k >= win));
            end
        end
        n_tests++;
        if (errs != 0) n_fail++;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] w;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        #1;
        chk(gate_stop == 16'hFFFF, "R1 gate_stop", {16'h0, gate_stop}, 32'hFFFF);
        chk(pll_stable == 1'b0, "R1 stable", {31'h0, pll_stable}, 0);
        rd(8'h10, r); chk(r == 32'h0, "R1 pll reg", r, 0);
        rd(8'h20, r); chk(r == 32'h0000FFFF, "R1 gate reg", r, 32'hFFFF);
        rd(8'h04, r); chk(r == 32'h0, "R1 lpwr reg", r, 0);
        rd(8'h24, r); chk(r == 32'h0, "R1 slpc reg", r, 0);

        // R2 R3 R4 vector table
        foreach (VEC[i]) begin
            w = {VEC[i][34:26], VEC[i][25:21], VEC[i][20:19], 6'h0, VEC[i][18], 1'b0, 8'h0};
            w = w | 32'h0000_04F5;
            wr(8'h10, w);
            #1;
            chk(ratio_num == VEC[i][17:8], "R3/R4 ratio_num", {22'h0, ratio_num}, {22'h0, VEC[i][17:8]});
            chk(ratio_den == VEC[i][7:0], "R3/R4 ratio_den", {24'h0, ratio_den}, {24'h0, VEC[i][7:0]});
            rd(8'h10, r);
            chk(r == (w & 32'hFFFF_030F), "R2 readback", r, w & 32'hFFFF_030F);
        end
        chk(pll_bypass == 1'b1, "R4 bypass out", {31'h0, pll_bypass}, 1);

        // R5 settle windows
        wr(8'h10, 32'h0); repeat (2) @(posedge clk);
        settle_run(4'd0, "R5 count0");
        wr(8'h10, 32'h0); repeat (2) @(posedge clk);
        settle_run(4'd2, "R5 count2");

        // R7 write to stable bit with enable kept
        wr(8'h10, 32'h0000_0102);
        #1 chk(pll_stable == 1'b1, "R7 stable kept", {31'h0, pll_stable}, 1);

        // R6 disable drop
        wr(8'h10, 32'h0000_0002);
        @(posedge clk); @(negedge clk);
        chk(pll_stable == 1'b0, "R6 drop", {31'h0, pll_stable}, 0);
        // R7 writing bit 10 alone does not set stable
        wr(8'h10, 32'h0000_0400);
        repeat (3) @(posedge clk);
        rd(8'h10, r);
        chk(r == 32'h0, "R7 read-only", r, 0);

        settle_run(4'd15, "R5 count15");

        // R6 restart after aborted settle
        wr(8'h10, 32'h0); repeat (2) @(posedge clk);
        wr(8'h10, 32'h0000_0103);
        repeat (5) @(posedge clk);
        wr(8'h10, 32'h0000_0003);
        repeat (2) @(posedge clk);
        settle_run(4'd3, "R6 restart");

        // R8 gate bits
        wr(8'h20, 32'h0000_0000);
        #1 chk(gate_stop == 16'h0, "R8 all run", {16'h0, gate_stop}, 0);
        wr(8'h20, 32'h0000_0800);
        #1 chk(gate_stop == 16'h0800, "R8 UDC bit11", {16'h0, gate_stop}, 32'h0800);
        wr(8'h20, 32'hFFFF_8001);
        #1 chk(gate_stop == 16'h8001, "R8 UART bits", {16'h0, gate_stop}, 32'h8001);
        rd(8'h20, r); chk(r == 32'h8001, "R8 readback", r, 32'h8001);

        // R9 low-power and sleep-control
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, r); chk(r == 32'h5, "R9 lpwr", r, 5);
        chk(sleep_on_wait && doze_en, "R9 lpwr outs", {30'h0, doze_en, sleep_on_wait}, 3);
        wr(8'h04, 32'h0000_0004);
        #1 chk(!sleep_on_wait && doze_en, "R9 doze only", {30'h0, doze_en, sleep_on_wait}, 2);
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h24, r); chk(r == 32'hC0, "R9 slpc", r, 32'hC0);
        wr(8'h24, 32'h0000_0040);
        #1 chk(usbd_clk_en && !usbh_suspend, "R9 usb", {30'h0, usbh_suspend, usbd_clk_en}, 1);

        // R10 unmapped offsets
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h30, 32'h0000_0000);
        #1;
        chk(gate_stop == 16'h8001, "R10 gate", {16'h0, gate_stop}, 32'h8001);
        chk(!sleep_on_wait && doze_en && usbd_clk_en && !usbh_suspend, "R10 outs",
            {28'h0, usbh_suspend, usbd_clk_en, doze_en, sleep_on_wait}, 32'h6);
        rd(8'h10, r); chk(r == 32'h0000_0503, "R10 pll reg", r, 32'h503);
        rd(8'h08, r); chk(r == 32'h0, "R10 read", r, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule